// File: doc/BRIEF.md
# Gradient Orientation Binning and Edge Thinning Stage

This stage sits between a gradient operator and a hysteresis thresholder in an edge-detection pipeline. Each cycle it may take one 3x3 window of gradient magnitudes, plus the signed horizontal and vertical gradient of the window's centre pixel. It puts the gradient orientation into one of four direction bins. No division, arctangent or angle table is used: the bin comes from comparing the two absolute gradient components against a 5:2 ratio, using only shifts and adds.

The two window neighbours that lie along the chosen bin are then compared with the centre. If the centre is not a local maximum along that line, it is replaced by zero, so broad ridges shrink to thin edges. The result leaves two cycles later, carrying the valid and end-of-line flags that came in with the window. It never stalls, so a window may be presented on every cycle.

Top module: `grad_nms_top`

## Requirements
- R1: Every window accepted with `win_valid` high produces exactly one output with `out_valid` high two clock cycles later, with `out_last` equal to the `win_last` given with it. `out_valid` is low in every cycle that has no window two cycles earlier.
- R2: With ax = |gx| and ay = |gy|, the bin is 0 degrees (code 00) when 2*ax >= 5*ay, that is, when ax is at least 2.5 times ay.
- R3: When R2 does not hold and 2*ay >= 5*ax, the bin is 90 degrees (code 10).
- R4: When neither component reaches 2.5 times the other, the bin is diagonal. It is 45 degrees (code 01) when gx and gy have the same sign, and 135 degrees (code 11) when their signs differ.
- R5: When gx and gy are both zero, the bin is code 00 and the output magnitude is 0, whatever the window holds.
- R6: Window element k (k = 3*row + column, row 0 at the top, column 0 at the left) occupies bits [k*MAG_W +: MAG_W] of `win_mag`; element 4 is the centre. The pair of neighbours compared is 3 and 5 for code 00, 0 and 8 for code 01, 1 and 7 for code 10, and 2 and 6 for code 11.
- R7: The output magnitude equals the centre when the centre is greater than or equal to both selected neighbours. Otherwise it is 0. A tie with a neighbour keeps the centre.
- R8: The six window elements outside the centre and the selected pair have no effect on the output magnitude.
- R9: While reset is asserted, and until the first window emerges, `out_valid`, `out_last`, `out_mag` and `out_dir` are all 0.
- R10: Windows presented on consecutive cycles each produce an output on consecutive cycles, in the same order, with no window dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid | input | 1 | A window is present this cycle |
| win_last | input | 1 | Window is the last of its line |
| win_mag | input | 9*MAG_W | Nine window magnitudes, element k at bits [k*MAG_W +: MAG_W] |
| win_gx | input | GRAD_W | Signed horizontal gradient of the centre |
| win_gy | input | GRAD_W | Signed vertical gradient of the centre |
| out_valid | output | 1 | Output word is valid |
| out_last | output | 1 | Output is the last of its line |
| out_mag | output | MAG_W | Thinned centre magnitude |
| out_dir | output | 2 | Direction bin code |

## Verification
Every result the stage produces (direction bin, thinned magnitude, valid and last flag) is due two rising edges after the window is driven. The bench drives each window on a falling edge and keeps a two-slot queue of expected results, filled from its own floating-point ratio model. At every falling edge it compares the outputs against the entry queued two steps earlier, so each result is sampled in the cycle it is due, and a missing, early or late output fails the valid comparison. Back-to-back windows and idle gaps both pass through the same queue, so ordering and the absence of extra outputs are checked as well.

// File: rtl/nms_pkg.sv
package nms_pkg;

  typedef enum logic [1:0] {
    DIR_0   = 2'b00,
    DIR_45  = 2'b01,
    DIR_90  = 2'b10,
    DIR_135 = 2'b11
  } dir_e;

  localparam int WIN_TAPS   = 9;
  localparam int CENTRE_TAP = 4;
  localparam int TAP_IDX_W  = 4;

  // First neighbour along the bin; the second is its mirror about the centre.
  function automatic logic [TAP_IDX_W-1:0] near_tap(dir_e d);
    logic [TAP_IDX_W-1:0] idx;
    case (d)
      DIR_0:   idx = 4'd3;
      DIR_45:  idx = 4'd0;
      DIR_90:  idx = 4'd1;
      default: idx = 4'd2;
    endcase
    return idx;
  endfunction

  function automatic logic [TAP_IDX_W-1:0] far_tap(dir_e d);
    return 4'(WIN_TAPS - 1) - near_tap(d);
  endfunction

endpackage

// File: rtl/nms_dir_class.sv
module nms_dir_class
  import nms_pkg::*;
#(
  parameter int GRAD_W = 10,
  parameter int MAG_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_last,
  input  logic [WIN_TAPS*MAG_W-1:0]   in_win,
  input  logic signed [GRAD_W-1:0]    in_gx,
  input  logic signed [GRAD_W-1:0]    in_gy,
  output logic                        s1_valid,
  output logic                        s1_last,
  output logic [WIN_TAPS*MAG_W-1:0]   s1_win,
  output dir_e                        s1_dir,
  output logic                        s1_flat
);

  localparam int SUM_W = GRAD_W + 3;

  function automatic logic [GRAD_W-1:0] abs_of(logic signed [GRAD_W-1:0] v);
    return v[GRAD_W-1] ? GRAD_W'(-v) : GRAD_W'(v);
  endfunction

  // a is at least 2.5 times b: 2a >= 4b + b
  function automatic logic dominates(logic [GRAD_W-1:0] a, logic [GRAD_W-1:0] b);
    logic [SUM_W-1:0] twice_a;
    logic [SUM_W-1:0] five_b;
    twice_a = SUM_W'(a) << 1;
    five_b  = (SUM_W'(b) << 2) + SUM_W'(b);
    return twice_a >= five_b;
  endfunction

  logic [GRAD_W-1:0] ax, ay;
  logic              x_dom, y_dom, flat_c, same_sign;
  dir_e              dir_c;

  assign ax        = abs_of(in_gx);
  assign ay        = abs_of(in_gy);
  assign x_dom     = dominates(ax, ay);
  assign y_dom     = dominates(ay, ax);
  assign flat_c    = (in_gx == '0) && (in_gy == '0);
  assign same_sign = (in_gx[GRAD_W-1] == in_gy[GRAD_W-1]);

  always_comb begin
    if (x_dom)          dir_c = DIR_0;
    else if (y_dom)     dir_c = DIR_90;
    else if (same_sign) dir_c = DIR_45;
    else                dir_c = DIR_135;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_win   <= '0;
      s1_dir   <= DIR_0;
      s1_flat  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_last  <= in_valid & in_last;
      s1_win   <= in_win;
      s1_dir   <= dir_c;
      s1_flat  <= flat_c;
    end
  end

  // R4: a diagonal bin needs two nonzero components
  p_diag_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_dir == DIR_45 || s1_dir == DIR_135)) |->
      ($past(in_gx) != '0 && $past(in_gy) != '0));

  // R4: 45 only for matching signs, 135 only for differing signs
  p_diag_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_dir == DIR_45) |-> ($past(in_gx[GRAD_W-1]) == $past(in_gy[GRAD_W-1])));

  // R5: flat gradient is binned as 0 degrees
  p_flat_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_flat) |-> (s1_dir == DIR_0));

endmodule

// File: rtl/nms_suppress.sv
module nms_suppress
  import nms_pkg::*;
#(
  parameter int MAG_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  logic                       s1_last,
  input  logic [WIN_TAPS*MAG_W-1:0]  s1_win,
  input  dir_e                       s1_dir,
  input  logic                       s1_flat,
  output logic                       out_valid,
  output logic                       out_last,
  output logic [MAG_W-1:0]           out_mag,
  output logic [1:0]                 out_dir
);

  logic [MAG_W-1:0]     tap [WIN_TAPS];
  logic [TAP_IDX_W-1:0] idx_near, idx_far;
  logic [MAG_W-1:0]     centre, nb_near, nb_far;
  logic                 keep_centre;

  for (genvar k = 0; k < WIN_TAPS; k++) begin : g_tap
    assign tap[k] = s1_win[k*MAG_W +: MAG_W];
  end

  assign idx_near    = near_tap(s1_dir);
  assign idx_far     = far_tap(s1_dir);
  assign centre      = tap[CENTRE_TAP];
  assign nb_near     = tap[idx_near];
  assign nb_far      = tap[idx_far];
  assign keep_centre = !s1_flat && (centre >= nb_near) && (centre >= nb_far);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_mag   <= '0;
      out_dir   <= 2'b00;
    end else begin
      out_valid <= s1_valid;
      out_last  <= s1_last;
      out_mag   <= keep_centre ? centre : '0;
      out_dir   <= s1_dir;
    end
  end

  // R7: a nonzero result is always the centre of the window before
  p_keep_centre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mag != '0) |-> (out_mag == $past(centre)));

  // R7: a centre strictly below a selected neighbour never survives
  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s1_valid) && ($past(centre) < $past(nb_near) || $past(centre) < $past(nb_far)))
      |-> (out_mag == '0));

endmodule

// File: rtl/grad_nms_top.sv
module grad_nms_top
  import nms_pkg::*;
#(
  parameter int GRAD_W = 10,
  parameter int MAG_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_valid,
  input  logic                       win_last,
  input  logic [9*MAG_W-1:0]         win_mag,
  input  logic signed [GRAD_W-1:0]   win_gx,
  input  logic signed [GRAD_W-1:0]   win_gy,
  output logic                       out_valid,
  output logic                       out_last,
  output logic [MAG_W-1:0]           out_mag,
  output logic [1:0]                 out_dir
);

  localparam int PIPE_DEPTH = 2;

  logic                      s1_valid, s1_last, s1_flat;
  logic [WIN_TAPS*MAG_W-1:0] s1_win;
  dir_e                      s1_dir;

  nms_dir_class #(.GRAD_W(GRAD_W), .MAG_W(MAG_W)) u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (win_valid),
    .in_last  (win_last),
    .in_win   (win_mag),
    .in_gx    (win_gx),
    .in_gy    (win_gy),
    .s1_valid (s1_valid),
    .s1_last  (s1_last),
    .s1_win   (s1_win),
    .s1_dir   (s1_dir),
    .s1_flat  (s1_flat)
  );

  nms_suppress #(.MAG_W(MAG_W)) u_supp (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_last   (s1_last),
    .s1_win    (s1_win),
    .s1_dir    (s1_dir),
    .s1_flat   (s1_flat),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_mag   (out_mag),
    .out_dir   (out_dir)
  );

  // cycles since reset, saturating at the pipeline depth, for the latency checks
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    warm <= 2'd0;
    else if (warm != 2'(PIPE_DEPTH)) warm <= warm + 2'd1;
  end

  // R1 / R10: each window emerges exactly two cycles later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'(PIPE_DEPTH)) |-> (out_valid == $past(win_valid, 2)));

  p_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'(PIPE_DEPTH) && out_valid) |-> (out_last == $past(win_last, 2)));

  // R5: a flat gradient gives a zero magnitude with code 00
  p_flat_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_gx == '0 && win_gy == '0) |=> ##1 (out_valid && out_mag == '0 && out_dir == 2'b00));

  // R9: outputs idle until something has entered
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'(PIPE_DEPTH)) |-> (!out_valid && out_mag == '0));

endmodule

// File: tb/grad_nms_top_test.sv
module grad_nms_top_test;

  localparam int GRAD_W = 10;
  localparam int MAG_W  = 8;

  typedef logic [8:0][MAG_W-1:0] win_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_valid = 1'b0, win_last = 1'b0;
  win_t win_w = '0;
  logic signed [GRAD_W-1:0] win_gx = '0, win_gy = '0;
  logic out_valid, out_last;
  logic [MAG_W-1:0] out_mag;
  logic [1:0] out_dir;

  grad_nms_top #(.GRAD_W(GRAD_W), .MAG_W(MAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_last(win_last),
    .win_mag(win_w), .win_gx(win_gx), .win_gy(win_gy),
    .out_valid(out_valid), .out_last(out_last), .out_mag(out_mag), .out_dir(out_dir)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // two-slot queue of expected results: slot 1 is due now
  bit    q_v[2];
  bit    q_l[2];
  int    q_m[2];
  int    q_d[2];
  string q_t[2];

  function automatic win_t mk(int a0, int a1, int a2, int a3, int a4,
                              int a5, int a6, int a7, int a8);
    win_t w;
    w[0] = 8'(a0); w[1] = 8'(a1); w[2] = 8'(a2);
    w[3] = 8'(a3); w[4] = 8'(a4); w[5] = 8'(a5);
    w[6] = 8'(a6); w[7] = 8'(a7); w[8] = 8'(a8);
    return w;
  endfunction

  function automatic int bin_of(int gx, int gy);
    real ax, ay;
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    if (gx == 0 && gy == 0) return 0;
    if (ax >= 2.5 * ay) return 0;
    if (ay >= 2.5 * ax) return 2;
    return ((gx > 0) == (gy > 0)) ? 1 : 3;
  endfunction

  function automatic int thin_of(win_t w, int gx, int gy);
    int d, a, b;
    if (gx == 0 && gy == 0) return 0;
    d = bin_of(gx, gy);
    case (d)
      0: begin a = 3; b = 5; end
      1: begin a = 0; b = 8; end
      2: begin a = 1; b = 7; end
      default: begin a = 2; b = 6; end
    endcase
    return (w[4] >= w[a] && w[4] >= w[b]) ? int'(w[4]) : 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit l, win_t w, int gx, int gy, string tag);
    @(negedge clk);
    cmp(q_t[1], "valid", int'(out_valid), int'(q_v[1]));
    if (q_v[1]) begin
      cmp(q_t[1], "magnitude", int'(out_mag), q_m[1]);
      cmp(q_t[1], "direction", int'(out_dir), q_d[1]);
      cmp(q_t[1], "last", int'(out_last), int'(q_l[1]));
    end
    q_v[1] = q_v[0]; q_l[1] = q_l[0]; q_m[1] = q_m[0]; q_d[1] = q_d[0]; q_t[1] = q_t[0];
    q_v[0] = v; q_l[0] = l; q_t[0] = tag;
    q_m[0] = thin_of(w, gx, gy);
    q_d[0] = bin_of(gx, gy);
    win_valid = v; win_last = l; win_w = w;
    win_gx = GRAD_W'(gx); win_gy = GRAD_W'(gy);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 0, 0, "R1 idle");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R9", "valid in reset", int'(out_valid), 0);
    cmp("R9", "magnitude in reset", int'(out_mag), 0);
    cmp("R9", "direction in reset", int'(out_dir), 0);
    cmp("R9", "last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_horizontal;
    step(1, 0, mk(0, 0, 0, 10, 50, 20, 0, 0, 0), 40, 3, "R2 horizontal keep");
    step(1, 0, mk(0, 0, 0, 60, 50, 20, 0, 0, 0), -40, 5, "R2 horizontal suppress");
    idle(2);
  endtask

  task automatic t_vertical;
    step(1, 0, mk(0, 30, 0, 0, 70, 0, 0, 69, 0), 2, -30, "R3 vertical keep");
    step(1, 0, mk(0, 30, 0, 0, 70, 0, 0, 71, 0), -1, 9, "R3 vertical suppress");
    idle(2);
  endtask

  task automatic t_diagonal;
    step(1, 0, mk(10, 0, 99, 0, 40, 0, 99, 0, 39), 20, 20, "R4 45 keep");
    step(1, 0, mk(41, 0, 0, 0, 40, 0, 0, 0, 1), -7, -6, "R4 45 suppress");
    step(1, 0, mk(99, 0, 12, 0, 40, 0, 11, 0, 99), 15, -12, "R4 135 keep");
    step(1, 0, mk(0, 0, 45, 0, 40, 0, 0, 0, 0), -9, 10, "R4 135 suppress");
    idle(2);
  endtask

  task automatic t_ratio_edge;
    step(1, 0, mk(0, 0, 0, 1, 9, 1, 0, 0, 0), 5, 2, "R2 exact 2.5 ratio");
    step(1, 0, mk(0, 0, 0, 1, 9, 1, 0, 0, 0), 4, 2, "R4 just under ratio");
    step(1, 0, mk(0, 0, 0, 1, 9, 1, 0, 0, 0), 7, -3, "R4 7 vs 3");
    step(1, 0, mk(0, 1, 0, 0, 9, 0, 0, 1, 0), -2, -5, "R3 exact 2.5 ratio");
    step(1, 0, mk(0, 0, 0, 1, 9, 1, 0, 0, 0), -512, 204, "R2 extreme negative gx");
    step(1, 0, mk(0, 0, 0, 1, 9, 1, 0, 0, 0), 3, 0, "R2 zero gy");
    step(1, 0, mk(0, 1, 0, 0, 9, 0, 0, 1, 0), 0, -1, "R3 zero gx");
    idle(2);
  endtask

  task automatic t_flat;
    step(1, 0, mk(0, 0, 0, 0, 200, 0, 0, 0, 0), 0, 0, "R5 flat gradient");
    idle(2);
  endtask

  task automatic t_ties;
    step(1, 0, mk(0, 0, 0, 80, 80, 80, 0, 0, 0), 50, 1, "R7 plateau tie");
    step(1, 0, mk(0, 80, 0, 0, 80, 0, 0, 79, 0), 0, 30, "R7 one-sided tie");
    idle(2);
  endtask

  task automatic t_ignored;
    step(1, 0, mk(250, 250, 250, 5, 60, 5, 250, 250, 250), 30, 1, "R8 off-axis ignored");
    step(1, 0, mk(255, 6, 255, 255, 60, 255, 255, 6, 255), 1, 30, "R6 vertical pair only");
    step(1, 0, mk(255, 255, 7, 255, 60, 255, 7, 255, 255), -10, 10, "R6 anti-diagonal pair only");
    idle(2);
  endtask

  task automatic t_stream;
    step(1, 0, mk(0, 0, 0, 1, 11, 2, 0, 0, 0), 10, 0, "R10 stream 0");
    step(1, 0, mk(0, 0, 0, 0, 12, 0, 0, 0, 0), 0, 10, "R10 stream 1");
    step(1, 0, mk(0, 0, 0, 0, 13, 0, 0, 0, 0), 6, 6, "R10 stream 2");
    step(1, 1, mk(0, 0, 0, 0, 14, 0, 0, 0, 0), 6, -6, "R1 end of line");
    step(0, 1, mk(0, 0, 0, 0, 15, 0, 0, 0, 0), 6, -6, "R1 gap ignores last");
    step(1, 0, mk(0, 0, 0, 20, 16, 0, 0, 0, 0), 9, 1, "R10 after gap");
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      q_v[i] = 0; q_l[i] = 0; q_m[i] = 0; q_d[i] = 0; q_t[i] = "R9 start";
    end
    t_reset();
    t_horizontal();
    t_vertical();
    t_diagonal();
    t_ratio_edge();
    t_flat();
    t_ties();
    t_ignored();
    t_stream();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule